// File: doc/BRIEF.md
# Forward 4x4 Scaled Walsh Transform

This block turns a 4x4 tile of signed 16-bit samples into sixteen signed 16-bit Walsh coefficients using exact integer arithmetic. The tile arrives as four rows of four samples over a valid/ready stream. Each row goes through a horizontal butterfly as it is accepted, and the result is written into a small transpose buffer. Once the fourth row is in, the vertical butterflies read the buffer column-wise. They widen the data, round it with a sign-dependent correction, and narrow it back to 16 bits.

The coefficients leave row-major, one row of four per beat, on a second valid/ready stream. The block works on one tile at a time. It accepts no new input until all four output rows have been taken, and it holds each output row steady while the consumer stalls.

Top module: `wht4x4_fwd`

## Requirements
- R1: After a reset cycle (rst_n low at a rising edge), in_ready is 1 and out_valid is 0.
- R2: in_ready is high throughout the load phase. The fourth accepted input row makes out_valid rise in the next cycle.
- R3: The row pass for samples p0..p3 (sample j in in_row bits [16j+15:16j]) works in 16-bit wrapping arithmetic. It forms A=(p0+p2)*4, D=(p1+p3)*4, C=(p1-p3)*4 and B=(p0-p2)*4. Its outputs are r0=A+D+bias, r1=B+C, r2=B-C and r3=A-D.
- R4: The bias in r0 is 1 when A is nonzero and 0 when A is zero. An all-zero tile therefore yields all-zero coefficients.
- R5: The column pass takes the row results e0,e1,e2,e3 of input rows 0..3 in one column, sign-extended to 32 bits. It forms S=e0+e2, T=e1+e3, U=e1-e3 and V=e0-e2. The raw outputs are y0=S+T, y1=V+U, y2=V-U and y3=S-T, computed with no 16-bit overflow.
- R6: Each raw column output y first gets 1 added if it is negative. It then gets 3 added, is shifted right arithmetically by 3, and keeps its low 16 bits without saturation.
- R7: Output row r carries y_r of column k in out_row bits [16k+15:16k]. Rows leave in order 0 to 3.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_row does not change at the next edge.
- R9: in_ready is 0 whenever out_valid is 1. Input presented during the drain phase is not taken, and the next tile's data is unaffected by it.
- R10: The fourth accepted output row brings in_ready back to 1 and out_valid to 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input row is presented |
| in_ready | output | 1 | Block accepts an input row this cycle |
| in_row | input | 64 | Four signed samples, sample j at bits [16j+15:16j] |
| out_valid | output | 1 | Output row is presented |
| out_ready | input | 1 | Consumer takes the output row this cycle |
| out_row | output | 64 | Four signed coefficients, column k at bits [16k+15:16k] |

## Verification
out_valid is due one cycle after the edge that accepts the fourth row, and the first coefficient row is valid in that same cycle. Each later row appears one cycle after the handshake of the row before it. in_ready returns one cycle after the fourth output handshake. The bench drives inputs and samples outputs on falling edges. At each falling edge it advances its behavioural integer model by exactly the handshakes the preceding rising edge saw, so every cycle's expected in_ready, out_valid and out_row can be compared directly. Random stalls on both sides exercise the hold and lock-out rules. Directed tiles cover all-zero, unit, and both extreme values.

// File: rtl/wht_pkg.sv
// Shared constants and types for the 4x4 Walsh transform.
// Assumes a fixed 4-point transform in both directions.
package wht_pkg;
    localparam int N_PTS = 4;
    typedef enum logic {PH_LOAD, PH_DRAIN} wht_phase_e;
endpackage

// File: rtl/wht_row_pass.sv
// Horizontal butterfly on one row of four samples, pre-scaled by 4,
// DC term biased by one when its sum term is nonzero.
// Assumes wrapping W-bit arithmetic throughout, as the transform requires.
module wht_row_pass #(
    parameter int W = 16
) (
    input  logic [4*W-1:0] row_i,
    output logic [4*W-1:0] row_o
);
    logic signed [W-1:0] x0, x1, x2, x3;
    logic signed [W-1:0] s02, s13, d13, d02;
    logic signed [W-1:0] ta, td, tc, tb;
    logic [W-1:0] dc_bias;

    // Butterfly with scale and DC bias, all in W bits.
    always_comb begin
        x0 = row_i[0*W +: W];
        x1 = row_i[1*W +: W];
        x2 = row_i[2*W +: W];
        x3 = row_i[3*W +: W];
        s02 = x0 + x2;
        s13 = x1 + x3;
        d13 = x1 - x3;
        d02 = x0 - x2;
        ta = s02 <<< 2;
        td = s13 <<< 2;
        tc = d13 <<< 2;
        tb = d02 <<< 2;
        dc_bias = {{(W-1){1'b0}}, (ta != '0)};
        row_o[0*W +: W] = ta + td + dc_bias;
        row_o[1*W +: W] = tb + tc;
        row_o[2*W +: W] = tb - tc;
        row_o[3*W +: W] = ta - td;
    end
endmodule

// File: rtl/wht_col_pass.sv
// Vertical butterfly on one column of four row-pass results.
// Widens to WW bits, corrects negatives by one, rounds with +3 and an
// arithmetic shift of 3, then truncates back to W bits.
// Assumes WW >= W + 3 so the sums cannot overflow.
module wht_col_pass #(
    parameter int W  = 16,
    parameter int WW = 32
) (
    input  logic [4*W-1:0] col_i,
    output logic [4*W-1:0] col_o
);
    logic signed [WW-1:0] e [4];
    logic signed [WW-1:0] raw [4];
    logic signed [WW-1:0] s_ev, s_od, d_od, d_ev;

    function automatic logic signed [W-1:0] round_narrow(input logic signed [WW-1:0] v);
        logic signed [WW-1:0] t;
        t = v + {{(WW-1){1'b0}}, v[WW-1]};
        t = t + WW'(3);
        return t[W+2:3];
    endfunction

    // Sign-extend the four column entries.
    always_comb begin
        for (int j = 0; j < 4; j++)
            e[j] = {{(WW-W){col_i[j*W+W-1]}}, col_i[j*W +: W]};
    end

    // Wide butterfly.
    always_comb begin
        s_ev = e[0] + e[2];
        s_od = e[1] + e[3];
        d_od = e[1] - e[3];
        d_ev = e[0] - e[2];
        raw[0] = s_ev + s_od;
        raw[1] = d_ev + d_od;
        raw[2] = d_ev - d_od;
        raw[3] = s_ev - s_od;
    end

    // Rounding and narrowing, one lane per output.
    for (genvar r = 0; r < 4; r++) begin : g_round
        assign col_o[r*W +: W] = round_narrow(raw[r]);
    end
endmodule

// File: rtl/wht_ctrl.sv
// Handshake controller: counts four accepted input rows, then four
// delivered output rows, and never overlaps the two phases.
// Assumes a single tile in flight.
module wht_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       out_ready,
    output logic       in_ready,
    output logic       out_valid,
    output logic       in_fire,
    output logic [1:0] row_idx
);
    import wht_pkg::*;

    wht_phase_e phase;
    logic       out_fire;

    // Phase decode and handshake strobes.
    always_comb begin
        in_ready  = (phase == PH_LOAD);
        out_valid = (phase == PH_DRAIN);
        in_fire   = in_valid && in_ready;
        out_fire  = out_valid && out_ready;
    end

    // Row counter and phase switching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_LOAD;
            row_idx <= '0;
        end else if (in_fire) begin
            row_idx <= row_idx + 2'd1;
            if (row_idx == 2'd3) phase <= PH_DRAIN;
        end else if (out_fire) begin
            row_idx <= row_idx + 2'd1;
            if (row_idx == 2'd3) phase <= PH_LOAD;
        end
    end
endmodule

// File: rtl/wht4x4_fwd.sv
// Top of the forward 4x4 scaled Walsh transform. Rows are transformed on
// entry and stored; columns are transformed from the stored tile and the
// requested output row is muxed out.
// Assumes one tile in flight; the buffer needs no reset since reads occur
// only after four writes.
module wht4x4_fwd #(
    parameter int SAMPLE_W = 16,
    parameter int WIDE_W   = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [4*SAMPLE_W-1:0] in_row,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [4*SAMPLE_W-1:0] out_row
);
    import wht_pkg::*;
    localparam int ROW_W = N_PTS * SAMPLE_W;

    logic             in_fire;
    logic [1:0]       row_idx;
    logic [ROW_W-1:0] row_res;
    logic [SAMPLE_W-1:0] tbuf [N_PTS][N_PTS];
    logic [ROW_W-1:0] col_in  [N_PTS];
    logic [ROW_W-1:0] col_res [N_PTS];

    wht_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .in_fire   (in_fire),
        .row_idx   (row_idx)
    );

    wht_row_pass #(.W(SAMPLE_W)) u_row (
        .row_i (in_row),
        .row_o (row_res)
    );

    // Store the row-pass result of each accepted row.
    always_ff @(posedge clk) begin
        if (in_fire) begin
            for (int j = 0; j < N_PTS; j++)
                tbuf[row_idx][j] <= row_res[j*SAMPLE_W +: SAMPLE_W];
        end
    end

    // Gather each buffer column for the vertical pass.
    always_comb begin
        for (int k = 0; k < N_PTS; k++)
            for (int i = 0; i < N_PTS; i++)
                col_in[k][i*SAMPLE_W +: SAMPLE_W] = tbuf[i][k];
    end

    for (genvar k = 0; k < N_PTS; k++) begin : g_col
        wht_col_pass #(.W(SAMPLE_W), .WW(WIDE_W)) u_col (
            .col_i (col_in[k]),
            .col_o (col_res[k])
        );
    end

    // Select the current output row from all four column results.
    always_comb begin
        for (int k = 0; k < N_PTS; k++)
            out_row[k*SAMPLE_W +: SAMPLE_W] = col_res[k][row_idx*SAMPLE_W +: SAMPLE_W];
    end
endmodule

// File: rtl/wht4x4_fwd_chk.sv
// Protocol checker for wht4x4_fwd, attached by bind. Tracks handshakes
// with its own counters. Assumes the same synchronous active-low reset.
module wht4x4_fwd_chk #(
    parameter int ROW_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [ROW_W-1:0] out_row
);
    logic [1:0] n_in, n_out;

    // Independent handshake counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_in  <= '0;
            n_out <= '0;
        end else begin
            if (in_valid && in_ready)   n_in  <= n_in + 2'd1;
            if (out_valid && out_ready) n_out <= n_out + 2'd1;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (in_ready && !out_valid)); // R1
    AST_FOURTH_ROW_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && n_in == 2'd3) |=> out_valid); // R2
    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_row))); // R8
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid)); // R9
    AST_LAST_OUT_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && n_out == 2'd3) |=> (in_ready && !out_valid)); // R10
endmodule

bind wht4x4_fwd wht4x4_fwd_chk #(.ROW_W(4*SAMPLE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_row   (out_row)
);

// File: tb/wht4x4_fwd_bench.sv
module wht4x4_fwd_bench;
    localparam int NBLK = 24;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_ready, out_valid, out_ready;
    logic [63:0] in_row, out_row;

    int checks = 0;
    int errors = 0;

    int    blk [NBLK][16];
    string tags [NBLK];
    logic [63:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    wht4x4_fwd u_wht4x4_fwd (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_row    (in_row),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_row   (out_row)
    );

    function automatic int w16(input int v);
        logic signed [15:0] t;
        t = v[15:0];
        return int'(t);
    endfunction

    // Behavioural model of the whole tile; pushes four expected rows.
    task automatic model_tile(input int b);
        int mid [16];
        int res [16];
        logic [63:0] r;
        for (int i = 0; i < 4; i++) begin
            int p0, p1, p2, p3, a, d, c, bb;
            p0 = blk[b][4*i]; p1 = blk[b][4*i+1]; p2 = blk[b][4*i+2]; p3 = blk[b][4*i+3];
            a  = w16((p0 + p2) * 4);
            d  = w16((p1 + p3) * 4);
            c  = w16((p1 - p3) * 4);
            bb = w16((p0 - p2) * 4);
            mid[4*i]   = w16(a + d + ((a != 0) ? 1 : 0));
            mid[4*i+1] = w16(bb + c);
            mid[4*i+2] = w16(bb - c);
            mid[4*i+3] = w16(a - d);
        end
        for (int k = 0; k < 4; k++) begin
            int s, t, u, v;
            int y [4];
            s = mid[k] + mid[8+k];
            t = mid[4+k] + mid[12+k];
            u = mid[4+k] - mid[12+k];
            v = mid[k] - mid[8+k];
            y[0] = s + t; y[1] = v + u; y[2] = v - u; y[3] = s - t;
            for (int q = 0; q < 4; q++) begin
                int z;
                z = y[q];
                if (z < 0) z = z + 1;
                z = (z + 3) >>> 3;
                res[4*q+k] = w16(z);
            end
        end
        for (int q = 0; q < 4; q++) begin
            for (int k = 0; k < 4; k++) r[16*k +: 16] = res[4*q+k][15:0];
            exp_q.push_back(r);
            tag_q.push_back(tags[b]);
        end
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    initial begin
        bit ph_out = 0;
        bit just_drained = 0;
        bit prev_stall = 0;
        logic [63:0] prev_row = '0;
        int bi = 0, ri = 0, oc = 0, cyc = 0;

        for (int b = 0; b < NBLK; b++) begin
            tags[b] = "R7";
            for (int j = 0; j < 16; j++) begin
                case (b)
                    0: blk[b][j] = 0;
                    1: blk[b][j] = (j == 0) ? 1 : 0;
                    2: blk[b][j] = 32767;
                    3: blk[b][j] = -32768;
                    4: blk[b][j] = (j % 3 == 0) ? -5 - j : 3 - j;
                    5: blk[b][j] = (j % 2 == 0) ? 32767 : -32768;
                    default: blk[b][j] = w16(int'($urandom));
                endcase
            end
        end
        tags[0] = "R4"; tags[1] = "R4"; tags[2] = "R3"; tags[3] = "R5";
        tags[4] = "R6"; tags[5] = "R5";

        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_row = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > 20000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=<20000", cyc);
                break;
            end
            // Compare DUT to model state for this cycle.
            check(in_ready == !ph_out, (cyc == 1) ? "R1" : (ph_out ? "R9" : (just_drained ? "R10" : "R2")),
                  "in_ready", 64'(in_ready), 64'(!ph_out));
            check(out_valid == ph_out, (cyc == 1) ? "R1" : "R2", "out_valid", 64'(out_valid), 64'(ph_out));
            if (ph_out && exp_q.size() > 0) begin
                check(out_row === exp_q[0], tag_q[0], "out_row", out_row, exp_q[0]);
                if (prev_stall) check(out_row === prev_row, "R8", "held row", out_row, prev_row);
            end
            just_drained = 0;
            if (bi == NBLK && !ph_out && exp_q.size() == 0) break;

            // Drive the next cycle's inputs.
            in_valid  = (bi < NBLK) && ($urandom % 10 < 7);
            in_row    = '0;
            if (bi < NBLK)
                for (int j = 0; j < 4; j++) in_row[16*j +: 16] = blk[bi][4*ri+j][15:0];
            if (ph_out && in_valid) in_row = ~in_row; // junk during drain, must be ignored
            out_ready = ($urandom % 10 < 6);

            // Advance the model by the handshakes of the coming edge.
            prev_stall = ph_out && !out_ready;
            prev_row   = out_row;
            if (!ph_out && in_valid) begin
                ri++;
                if (ri == 4) begin
                    model_tile(bi);
                    bi++;
                    ri = 0;
                    ph_out = 1;
                end
            end else if (ph_out && out_ready) begin
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
                oc++;
                if (oc == 4) begin
                    oc = 0;
                    ph_out = 0;
                    just_drained = 1;
                end
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule